// File: doc/BRIEF.md
# Speculative Lock Elision Controller

This controller sits beside one core and lets a critical section run without taking its lock. A begin pulse captures a snapshot of the architectural register state and opens a speculative region. While the region is open, the core's loads and stores are accepted here. Stores are held in a private write buffer that no other core can see, and each store also asks the coherence fabric for exclusive ownership of its line. Every line that a load or store touches is recorded as marked. Loads look into the buffer first and return the data of the youngest matching store.

The region ends in one of two ways. If another core invalidates a marked line or asks for exclusive access to it, or if the write buffer or the line-tracking table runs out of room, the region is abandoned. In that case the buffer and all marks are dropped, the snapshot is offered back for restore, and a fallback pulse tells the core to take the lock for real. If the end pulse arrives first, the region commits. The buffer drains oldest-first to memory over a valid/ready channel. While it drains, snoops to marked lines are held back, so other cores see every buffered write take effect at once. The marks are cleared in the cycle in which the last write is handed over.

Request channel: a request transfers when `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high exactly while a region is open, and no other condition lowers it. Load responses have no back-pressure. Drain channel: once `mem_valid_o` rises it stays high, with address and data unchanged, until `mem_ready_i` accepts it. Snoop channel: a snoop is taken when `snp_valid_i` and `snp_ready_o` are both high. A held snoop must be kept presented by its source.

Top module: `sle_ctrl`

## Requirements
- R1: A begin pulse while idle captures `ckpt_state_i` into `ckpt_state_o` and raises `spec_o` from the next cycle. A begin pulse while a region is open or committing is ignored and leaves the checkpoint unchanged.
- R2: `req_ready_o` is high exactly while `spec_o` is high, and is low after reset.
- R3: An accepted load (`req_we_i`=0) gives `ld_valid_o` one cycle later. `ld_fwd_o`=1 and `ld_data_o` equal to the data of the youngest buffered store to the same full address, or `ld_fwd_o`=0 and `ld_data_o`=0 when no buffered store matches.
- R4: Each accepted store that does not abort the region raises `own_req_o` one cycle later, with `own_line_o` equal to the store address shifted right by the line-offset width.
- R5: Snoop kinds are 0 = read, 1 = invalidate, 2 = exclusive. An invalidate or exclusive snoop whose line is marked aborts an open region. A read snoop never aborts.
- R6: A store accepted while the write buffer already holds WB_DEPTH entries aborts the region.
- R7: An access to an unmarked line while all TRK_DEPTH tracking slots are used aborts the region. An access to an already marked line takes no new slot and never aborts.
- R8: On abort, `abort_o` pulses for one cycle in the cycle after the cause. `spec_o` is low, the load response of the aborting cycle is suppressed, `ckpt_state_o` still holds the checkpoint, and all buffered stores and marks are discarded.
- R9: An end pulse in an open region starts commit. Buffered stores leave on `mem_*` oldest first, one per handshake, with the payload stable under back-pressure.
- R10: During commit, `snp_ready_o` is low for snoops to marked lines and high for other lines, and commit never aborts.
- R11: When the last buffered store is accepted, or at once if the buffer is empty, all marks are cleared. `commit_done_o` pulses in the next cycle and the controller is idle.
- R12: When an abort cause and an end pulse fall in the same cycle, the abort wins and nothing drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| begin_i | input | 1 | Start of an elided critical section |
| end_i | input | 1 | End of the critical section |
| ckpt_state_i | input | CKPT_W | Register state to checkpoint |
| ckpt_state_o | output | CKPT_W | Checkpointed register state |
| spec_o | output | 1 | Speculative region open |
| commit_busy_o | output | 1 | Commit drain in progress |
| abort_o | output | 1 | Misspeculation pulse: restore and take the lock |
| commit_done_o | output | 1 | Commit finished pulse |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Core request accepted |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Store data |
| ld_valid_o | output | 1 | Load response valid |
| ld_fwd_o | output | 1 | Load data came from the write buffer |
| ld_data_o | output | DW | Forwarded load data |
| own_req_o | output | 1 | Exclusive-ownership request |
| own_line_o | output | AW-OFF_W | Line of the ownership request |
| snp_valid_i | input | 1 | Snoop valid |
| snp_kind_i | input | 2 | Snoop kind (0 read, 1 invalidate, 2 exclusive) |
| snp_addr_i | input | AW | Snoop word address |
| snp_ready_o | output | 1 | Snoop accepted |
| mem_valid_o | output | 1 | Drain write valid |
| mem_ready_i | input | 1 | Drain write accepted |
| mem_addr_o | output | AW | Drain write address |
| mem_data_o | output | DW | Drain write data |

## Verification
The bench builds the controller with a 12-bit address, 16-bit data, four words per line, a four-entry write buffer and three tracking slots. These small sizes bring both overflow aborts within a handful of requests, and they let random regions spread over three lines without ever running out of slots. A full buffer of repeated stores to one address shows that the youngest store is forwarded and that the drain keeps program order. Random back-pressure on the drain channel exercises payload holding and the clearing of marks on the final handshake.

// File: rtl/sle_pkg.sv
package sle_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SPEC   = 2'd1,
    ST_COMMIT = 2'd2
  } sle_state_e;

  localparam logic [1:0] SNP_READ = 2'd0;
  localparam logic [1:0] SNP_INV  = 2'd1;
  localparam logic [1:0] SNP_EXCL = 2'd2;
endpackage

// File: rtl/sle_track.sv
module sle_track #(
  parameter int DEPTH = 8,
  parameter int LW    = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          mark_i,
  input  logic [LW-1:0] acc_line_i,
  output logic          acc_hit_o,
  output logic          full_o,
  input  logic [LW-1:0] snp_line_i,
  output logic          snp_hit_o
);
  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] acc_m;
  logic [DEPTH-1:0] snp_m;
  logic [DEPTH-1:0] free_oh;

  // lowest free slot wins
  always_comb begin
    free_oh = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_oh    = '0;
        free_oh[i] = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [LW-1:0] tag;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld[g] <= 1'b0;
        tag    <= '0;
      end else if (clear_i) begin
        vld[g] <= 1'b0;
      end else if (mark_i && free_oh[g]) begin
        vld[g] <= 1'b1;
        tag    <= acc_line_i;
      end
    end
    assign acc_m[g] = vld[g] && (tag == acc_line_i);
    assign snp_m[g] = vld[g] && (tag == snp_line_i);
  end

  assign acc_hit_o = |acc_m;
  assign snp_hit_o = |snp_m;
  assign full_o    = &vld;

  AST_NO_MARK_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    mark_i |-> !full_o); // R7
  AST_UNIQUE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_m)); // R7
  AST_MARKS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (vld == '0)); // R11
endmodule

// File: rtl/sle_wbuf.sv
module sle_wbuf #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic [AW-1:0] lk_addr_i,
  output logic          lk_hit_o,
  output logic [DW-1:0] lk_data_o,
  input  logic          drain_en_i,
  output logic          mem_valid_o,
  input  logic          mem_ready_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  output logic          full_o,
  output logic          last_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] cnt;
  logic          pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign mem_valid_o = drain_en_i && (cnt != '0);
  assign pop         = mem_valid_o && mem_ready_i;
  assign mem_addr_o  = addr_q[head];
  assign mem_data_o  = data_q[head];
  assign full_o      = (int'(cnt) == DEPTH);
  assign last_o      = (cnt == '0) || ((int'(cnt) == 1) && pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else if (flush_i) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (push_i) tail <= nxt(tail);
      if (pop)    head <= nxt(head);
      cnt <= cnt + CW'(push_i) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push_i && !flush_i) begin
      addr_q[tail] <= push_addr_i;
      data_q[tail] <= push_data_i;
    end
  end

  // scan oldest to youngest; the last match is the youngest store
  always_comb begin
    lk_hit_o  = 1'b0;
    lk_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      int j;
      j = int'(head) + i;
      if (j >= DEPTH) j = j - DEPTH;
      if ((i < int'(cnt)) && (addr_q[j[PW-1:0]] == lk_addr_i)) begin
        lk_hit_o  = 1'b1;
        lk_data_o = data_q[j[PW-1:0]];
      end
    end
  end

  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o); // R6
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o))); // R9
endmodule

// File: rtl/sle_fsm.sv
module sle_fsm
  import sle_pkg::*;
#(
  parameter int CKPT_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              begin_i,
  input  logic              end_i,
  input  logic [CKPT_W-1:0] ckpt_i,
  input  logic              ovf_i,
  input  logic              cfl_i,
  input  logic              drain_last_i,
  output sle_state_e        state_o,
  output logic              abort_now_o,
  output logic              clear_o,
  output logic              abort_o,
  output logic              commit_done_o,
  output logic [CKPT_W-1:0] ckpt_o
);
  sle_state_e state, state_n;
  logic       finish;

  assign abort_now_o = (state == ST_SPEC) && (ovf_i || cfl_i);
  assign finish      = (state == ST_COMMIT) && drain_last_i;
  assign clear_o     = abort_now_o || finish;
  assign state_o     = state;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:   if (begin_i) state_n = ST_SPEC;
      ST_SPEC:   if (abort_now_o) state_n = ST_IDLE;
                 else if (end_i) state_n = ST_COMMIT;
      ST_COMMIT: if (drain_last_i) state_n = ST_IDLE;
      default:   state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      abort_o       <= 1'b0;
      commit_done_o <= 1'b0;
      ckpt_o        <= '0;
    end else begin
      state         <= state_n;
      abort_o       <= abort_now_o;
      commit_done_o <= finish;
      if ((state == ST_IDLE) && begin_i) ckpt_o <= ckpt_i;
    end
  end

  AST_ABORT_LANDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (state == ST_IDLE)); // R8
  AST_COMMIT_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COMMIT) |=> !abort_o); // R10
  AST_CKPT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(ckpt_o)); // R1
endmodule

// File: rtl/sle_ctrl.sv
module sle_ctrl
  import sle_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int OFF_W     = 4,
  parameter int WB_DEPTH  = 8,
  parameter int TRK_DEPTH = 8,
  parameter int CKPT_W    = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              begin_i,
  input  logic              end_i,
  input  logic [CKPT_W-1:0] ckpt_state_i,
  output logic [CKPT_W-1:0] ckpt_state_o,
  output logic              spec_o,
  output logic              commit_busy_o,
  output logic              abort_o,
  output logic              commit_done_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              ld_valid_o,
  output logic              ld_fwd_o,
  output logic [DW-1:0]     ld_data_o,
  output logic              own_req_o,
  output logic [AW-OFF_W-1:0] own_line_o,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_kind_i,
  input  logic [AW-1:0]     snp_addr_i,
  output logic              snp_ready_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_data_o
);
  localparam int LW = AW - OFF_W;

  sle_state_e    state;
  logic          in_spec, in_commit, acc, abort_now, clear;
  logic [LW-1:0] acc_line, snp_line;
  logic          trk_acc_hit, trk_full, trk_snp_hit;
  logic          wb_full, wb_last, wb_hit;
  logic [DW-1:0] wb_data;
  logic          ovf, cfl, push, mark, snp_hostile;

  assign in_spec   = (state == ST_SPEC);
  assign in_commit = (state == ST_COMMIT);
  assign acc       = req_valid_i && in_spec;
  assign acc_line  = req_addr_i[AW-1:OFF_W];
  assign snp_line  = snp_addr_i[AW-1:OFF_W];

  assign snp_hostile = (snp_kind_i == SNP_INV) || (snp_kind_i == SNP_EXCL);
  assign ovf  = acc && ((req_we_i && wb_full) || (!trk_acc_hit && trk_full));
  assign cfl  = snp_valid_i && snp_hostile && trk_snp_hit;
  assign push = acc && req_we_i && !abort_now;
  assign mark = acc && !trk_acc_hit && !abort_now;

  assign req_ready_o   = in_spec;
  assign spec_o        = in_spec;
  assign commit_busy_o = in_commit;
  assign snp_ready_o   = !(in_commit && trk_snp_hit);

  sle_fsm #(.CKPT_W(CKPT_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .begin_i       (begin_i),
    .end_i         (end_i),
    .ckpt_i        (ckpt_state_i),
    .ovf_i         (ovf),
    .cfl_i         (cfl),
    .drain_last_i  (wb_last),
    .state_o       (state),
    .abort_now_o   (abort_now),
    .clear_o       (clear),
    .abort_o       (abort_o),
    .commit_done_o (commit_done_o),
    .ckpt_o        (ckpt_state_o)
  );

  sle_track #(.DEPTH(TRK_DEPTH), .LW(LW)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear),
    .mark_i     (mark),
    .acc_line_i (acc_line),
    .acc_hit_o  (trk_acc_hit),
    .full_o     (trk_full),
    .snp_line_i (snp_line),
    .snp_hit_o  (trk_snp_hit)
  );

  sle_wbuf #(.DEPTH(WB_DEPTH), .AW(AW), .DW(DW)) u_wbuf (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (abort_now),
    .push_i      (push),
    .push_addr_i (req_addr_i),
    .push_data_i (req_wdata_i),
    .lk_addr_i   (req_addr_i),
    .lk_hit_o    (wb_hit),
    .lk_data_o   (wb_data),
    .drain_en_i  (in_commit),
    .mem_valid_o (mem_valid_o),
    .mem_ready_i (mem_ready_i),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o),
    .full_o      (wb_full),
    .last_o      (wb_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_valid_o <= 1'b0;
      ld_fwd_o   <= 1'b0;
      ld_data_o  <= '0;
      own_req_o  <= 1'b0;
      own_line_o <= '0;
    end else begin
      ld_valid_o <= acc && !req_we_i && !abort_now;
      ld_fwd_o   <= wb_hit;
      ld_data_o  <= wb_hit ? wb_data : '0;
      own_req_o  <= push;
      if (push) own_line_o <= acc_line;
    end
  end

  AST_OWN_FOLLOWS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    own_req_o |-> $past(req_valid_i && req_we_i && req_ready_o)); // R4
  AST_LOAD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid_o |-> $past(req_valid_i && !req_we_i && req_ready_o)); // R3
  AST_NO_DRAIN_OUTSIDE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o |-> commit_busy_o); // R12
endmodule

// File: tb/test_sle_ctrl.sv
module test_sle_ctrl;
  localparam int AW = 12, DW = 16, OFF_W = 2, WBD = 4, TRKD = 3, CKW = 16;
  localparam int LW = AW - OFF_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic begin_i = 0, end_i = 0, req_valid_i = 0, req_we_i = 0;
  logic [CKW-1:0] ckpt_state_i = '0, ckpt_state_o;
  logic spec_o, commit_busy_o, abort_o, commit_done_o, req_ready_o;
  logic [AW-1:0] req_addr_i = '0, snp_addr_i = '0, mem_addr_o;
  logic [DW-1:0] req_wdata_i = '0, ld_data_o, mem_data_o;
  logic ld_valid_o, ld_fwd_o, own_req_o, snp_valid_i = 0, snp_ready_o;
  logic mem_valid_o, mem_ready_i = 0;
  logic [LW-1:0] own_line_o;
  logic [1:0] snp_kind_i = 2'd0;

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] m_addr[$];
  logic [DW-1:0] m_data[$];

  always #2.5 clk = ~clk;

  sle_ctrl #(.AW(AW), .DW(DW), .OFF_W(OFF_W), .WB_DEPTH(WBD),
             .TRK_DEPTH(TRKD), .CKPT_W(CKW)) i_sle_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [DW:0] exp_fwd(input logic [AW-1:0] a);
    logic [DW:0] r = '0;
    for (int i = 0; i < m_addr.size(); i++)
      if (m_addr[i] == a) r = {1'b1, m_data[i]};
    return r;
  endfunction

  task automatic do_begin(input logic [CKW-1:0] ck);
    begin_i = 1; ckpt_state_i = ck;
    tick();
    begin_i = 0;
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid_i = 1; req_we_i = 1; req_addr_i = a; req_wdata_i = d;
    tick();
    req_valid_i = 0; req_we_i = 0;
    m_addr.push_back(a); m_data.push_back(d);
    chk("R4 own_req", own_req_o, 1);
    chk("R4 own_line", own_line_o, a >> OFF_W);
  endtask

  task automatic do_load(input logic [AW-1:0] a);
    logic [DW:0] e;
    e = exp_fwd(a);
    req_valid_i = 1; req_we_i = 0; req_addr_i = a;
    tick();
    req_valid_i = 0;
    chk("R3 ld_valid", ld_valid_o, 1);
    chk("R3 ld_fwd", ld_fwd_o, e[DW]);
    chk("R3 ld_data", ld_data_o, e[DW-1:0]);
  endtask

  task automatic snoop(input logic [1:0] k, input logic [AW-1:0] a);
    snp_valid_i = 1; snp_kind_i = k; snp_addr_i = a;
    tick();
    snp_valid_i = 0;
  endtask

  task automatic do_commit(input bit rnd_bp);
    int guard = 0;
    end_i = 1;
    tick();
    end_i = 0;
    forever begin
      bit fire;
      mem_ready_i = rnd_bp ? 1'($urandom % 2) : 1'b1;
      #1;
      if (mem_valid_o) begin
        if (m_addr.size() == 0) chk("R9 unexpected drain", 1, 0);
        else begin
          chk("R9 drain addr", mem_addr_o, m_addr[0]);
          chk("R9 drain data", mem_data_o, m_data[0]);
        end
      end
      fire = mem_valid_o && mem_ready_i;
      @(posedge clk); #1;
      if (fire && m_addr.size() > 0) begin
        void'(m_addr.pop_front()); void'(m_data.pop_front());
      end
      if (commit_done_o || ++guard > 100) break;
    end
    mem_ready_i = 0;
    chk("R11 done seen", commit_done_o, 1);
    chk("R11 all drained", m_addr.size(), 0);
    chk("R11 idle spec", spec_o, 0);
    chk("R11 idle busy", commit_busy_o, 0);
  endtask

  task automatic exp_abort(input string req, input logic [CKW-1:0] ck);
    chk({req, " abort_o"}, abort_o, 1);
    chk("R8 spec low", spec_o, 0);
    chk("R8 ckpt", ckpt_state_o, ck);
    m_addr.delete(); m_data.delete();
    tick();
    chk("R8 abort pulse", abort_o, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) tick();
    chk("R2 reset ready", req_ready_o, 0);
    chk("R2 reset spec", spec_o, 0);
    chk("R8 reset abort", abort_o, 0);
    chk("R9 reset mem_valid", mem_valid_o, 0);
    rst_n = 1;
    tick();

    // forwarding and drain order, R1 R3 R9 R10 R11
    do_begin(16'hA1A1);
    chk("R1 spec", spec_o, 1);
    chk("R2 ready", req_ready_o, 1);
    do_store(12'h010, 16'h1111);
    do_load(12'h010);
    do_store(12'h010, 16'h2222);
    do_store(12'h011, 16'h3333);
    do_load(12'h010);
    do_load(12'h013);
    do_load(12'h020);
    // commit with a held snoop on a marked line
    end_i = 1; tick(); end_i = 0;
    chk("R9 busy", commit_busy_o, 1);
    snp_valid_i = 1; snp_kind_i = 2'd1; snp_addr_i = 12'h012; #1;
    chk("R10 held snoop", snp_ready_o, 0);
    snp_addr_i = 12'h100; #1;
    chk("R10 other snoop", snp_ready_o, 1);
    snp_valid_i = 0;
    m_addr.push_front(12'h0); m_data.push_front(16'h0);
    void'(m_addr.pop_front()); void'(m_data.pop_front());
    begin : drain_directed
      int guard = 0;
      while (!commit_done_o && guard < 50) begin
        bit fire;
        mem_ready_i = 1'($urandom % 2);
        #1;
        if (mem_valid_o && m_addr.size() > 0) begin
          chk("R9 drain addr", mem_addr_o, m_addr[0]);
          chk("R9 drain data", mem_data_o, m_data[0]);
        end
        fire = mem_valid_o && mem_ready_i;
        @(posedge clk); #1;
        if (fire) begin void'(m_addr.pop_front()); void'(m_data.pop_front()); end
        guard++;
      end
      mem_ready_i = 0;
      chk("R11 done", commit_done_o, 1);
      chk("R11 drained", m_addr.size(), 0);
    end

    // marks cleared by commit; read snoop harmless; begin ignored in region
    do_begin(16'hB2B2);
    snoop(2'd1, 12'h010);
    chk("R11 marks cleared", spec_o, 1);
    do_load(12'h040);
    snoop(2'd0, 12'h041);
    chk("R5 read snoop", spec_o, 1);
    chk("R5 read snoop abort", abort_o, 0);
    do_begin(16'hC3C3);
    do_store(12'h044, 16'h4444);
    snoop(2'd1, 12'h043);
    exp_abort("R5 inv", 16'hB2B2);
    chk("R1 begin ignored ckpt", ckpt_state_o, 16'hB2B2);

    // buffer discarded after abort
    do_begin(16'hD4D4);
    do_load(12'h044);
    snoop(2'd2, 12'h045);
    exp_abort("R5 excl", 16'hD4D4);

    // write buffer overflow R6
    do_begin(16'hE5E5);
    for (int i = 0; i < WBD; i++) do_store(12'h080, 16'(i));
    do_load(12'h080);
    req_valid_i = 1; req_we_i = 1; req_addr_i = 12'h081; req_wdata_i = 16'h9;
    tick();
    req_valid_i = 0; req_we_i = 0;
    chk("R6 no own_req", own_req_o, 0);
    exp_abort("R6 overflow", 16'hE5E5);

    // tracker overflow R7
    do_begin(16'hF6F6);
    for (int i = 0; i < TRKD; i++) do_load(12'(i * 4 + 12'h200));
    do_load(12'h201);
    chk("R7 marked line ok", spec_o, 1);
    req_valid_i = 1; req_we_i = 0; req_addr_i = 12'h300;
    tick();
    req_valid_i = 0;
    chk("R8 ld suppressed", ld_valid_o, 0);
    exp_abort("R7 overflow", 16'hF6F6);

    // abort beats end R12
    do_begin(16'h1357);
    do_store(12'h400, 16'hAAAA);
    end_i = 1; snp_valid_i = 1; snp_kind_i = 2'd2; snp_addr_i = 12'h402;
    tick();
    end_i = 0; snp_valid_i = 0;
    chk("R12 not committing", commit_busy_o, 0);
    chk("R12 no drain", mem_valid_o, 0);
    exp_abort("R12", 16'h1357);

    // empty commit R11
    do_begin(16'h2468);
    do_commit(0);

    // random regions
    for (int r = 0; r < 30; r++) begin
      int ns = 0;
      do_begin(16'(r));
      for (int k = 0; k < int'($urandom % 9); k++) begin
        logic [AW-1:0] a;
        a = 12'(($urandom % 3) * 4 + ($urandom % 4) + 12'h600);
        if (($urandom % 2) == 1 && ns < WBD) begin
          do_store(a, 16'($urandom));
          ns++;
        end else do_load(a);
        if (($urandom % 4) == 0) begin
          snoop(2'd0, a);
          chk("R5 rand read snoop", spec_o, 1);
        end
      end
      do_commit(1);
    end

    summary();
  end
endmodule